// File: doc/BRIEF.md
# Stereo Sample-Rate-Converter Input Buffer with Gain Scaling

This block sits at the front of a stereo sample-rate converter. Each time the input-rate strobe fires, it takes one left and one right sample and multiplies each by a gain. It then writes the results into two per-channel RAMs of 512 words, where the convolution stage reads them. The gain has two factors. The first is a rate factor: when the output rate is below the input rate, samples are scaled down by the output/input ratio so that the longer convolution cannot saturate. The second is a soft-mute ramp that fades the signal out or back in linearly.

The write address is a free-running input-sample count plus a guard offset. The offset is 16 samples plus a 7-bit delay field taken from a control byte, which keeps the filter's read pointer clear of fresh writes. The top bit of the same control byte requests the mute. The filter reads through one registered read port. Each channel's RAM has a single port, so a write takes that port for its cycle and a read requested in the same cycle is dropped.

Top module: `src_in_buffer`

## Requirements
- R1: After reset, `rd_valid` is 0, the sample counter is 0 (the first stored pair lands at address 16 + `ctl_byte[6:0]`), and the mute gain is full scale (1024/1024).
- R2: On a cycle with `in_stb` high, the pair is stored at address (N + 16 + `ctl_byte[6:0]`) mod 512, where N is the number of earlier strobes since reset. `ctl_byte` is sampled on that strobe cycle.
- R3: The guard offset is 16 when `ctl_byte[6:0]` is 0 and 143 when it is 127.
- R4: Addresses wrap modulo 512, and the sample counter wraps after 512 strobes.
- R5: `rate_q` is unsigned, with 0x8000 meaning a ratio of 1.0. The rate factor is min(`rate_q`, 0x8000). The intermediate value is floor(x · factor / 32768), where x is the signed 24-bit sample.
- R6: While `ctl_byte[7]` is 1 on a strobe, the mute gain g falls by 1 (to no lower than 0). While it is 0, g rises by 1 (to no higher than 1024). The stored value is floor(intermediate · g / 1024), where g is the gain held before that strobe's update.
- R7: After 1024 or more consecutive muted strobes, every newly stored sample is 0.
- R8: The RAM write happens at the second rising edge after the strobe edge. A read issued with `rd_en` returns `rd_left`/`rd_right` with `rd_valid` = 1 one edge later.
- R9: A read requested at the edge where a write happens is dropped. `rd_valid` is 0 afterwards, and `rd_left`/`rd_right` keep their previous values.
- R10: Strobes may arrive on consecutive cycles, and every one of them is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | 1 | Input-rate strobe, one cycle per sample pair |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| ctl_byte | input | 8 | Bit 7 requests mute; bits 6:0 add to the guard offset |
| rate_q | input | 16 | Output/input rate ratio, 0x8000 = 1.0 |
| rd_en | input | 1 | Read request from the filter |
| rd_addr | input | 9 | Read address |
| rd_left | output | 24 | Left word read |
| rd_right | output | 24 | Right word read |
| rd_valid | output | 1 | Read data valid |

## Verification
The bench drives ratios above 1.0 and checks that they clamp to unity. A design missing the clamp would amplify the signal and wrap it. The bench also probes the offset at both ends of the 7-bit field and runs the counter past 512. A wrong offset or a missing wrap sends samples to addresses the filter never reads.

The mute is held through more than 1024 strobes and then released. An off-by-one in the ramp, or applying the gain after its update, shows up as a wrong attenuated value or as a residue where the output should be zero. A read is also aimed at the exact write edge. A design that lets the read through would assert valid or corrupt the held data.

// File: rtl/src_buf_pkg.sv
package src_buf_pkg;
  localparam int RAMP_LOG = 10;
  localparam int RAMP_W   = RAMP_LOG + 1;
  localparam int RAMP_FULL = 1 << RAMP_LOG;
  localparam int GUARD_MIN = 16;
  localparam int DELAY_W  = 7;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/src_buf_addr.sv
module src_buf_addr
  import src_buf_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stb,
  input  logic [DELAY_W-1:0]  delay,
  output logic [ADDR_W-1:0]   wr_addr
);
  localparam logic [ADDR_W-1:0] GUARD = ADDR_W'(GUARD_MIN);

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (stb) cnt_q <= cnt_q + 1'b1;
  end

  always_comb wr_addr = cnt_q + GUARD + ADDR_W'(delay);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    stb |=> cnt_q == $past(cnt_q) + 1'b1);
  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(cnt_q));
  p_guard_span_r3: assert property (@(posedge clk) disable iff (rst)
    (ADDR_W'(wr_addr - cnt_q) >= GUARD) &&
    (ADDR_W'(wr_addr - cnt_q) <= GUARD + ADDR_W'((1 << DELAY_W) - 1)));
endmodule

// File: rtl/src_buf_gain.sv
module src_buf_gain
  import src_buf_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stb,
  input  logic               mute,
  input  logic [RATIO_W-1:0] ratio,
  output logic [RATIO_W-1:0] rate_gain,
  output logic [RAMP_W-1:0]  ramp
);
  localparam logic [RATIO_W-1:0] UNITY = RATIO_W'(1) << (RATIO_W - 1);
  localparam logic [RAMP_W-1:0]  FULL  = RAMP_W'(RAMP_FULL);

  logic [RAMP_W-1:0] ramp_q;
  ramp_dir_e         dir;

  always_comb begin
    dir = RAMP_HOLD;
    if (stb) begin
      if (mute && ramp_q != '0)        dir = RAMP_DOWN;
      else if (!mute && ramp_q != FULL) dir = RAMP_UP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ramp_q <= FULL;
    else begin
      case (dir)
        RAMP_DOWN: ramp_q <= ramp_q - 1'b1;
        RAMP_UP:   ramp_q <= ramp_q + 1'b1;
        default:   ramp_q <= ramp_q;
      endcase
    end
  end

  always_comb rate_gain = (ratio >= UNITY) ? UNITY : ratio;
  assign ramp = ramp_q;

  p_ramp_bound_r6: assert property (@(posedge clk) disable iff (rst)
    ramp_q <= FULL);
  p_ramp_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (stb && mute && ramp_q != '0) |=> ramp_q == $past(ramp_q) - 1'b1);
  p_ramp_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (stb && !mute && ramp_q != FULL) |=> ramp_q == $past(ramp_q) + 1'b1);
  p_ramp_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(ramp_q));
endmodule

// File: rtl/src_buf_scale.sv
module src_buf_scale
  import src_buf_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  din,
  input  logic [RATIO_W-1:0] rate_gain,
  input  logic [RAMP_W-1:0]  ramp,
  output logic [DATA_W-1:0]  dout
);
  localparam int P1_W = DATA_W + RATIO_W + 1;
  localparam int P2_W = DATA_W + RAMP_W + 1;

  logic signed [P1_W-1:0]   prod_rate;
  logic signed [P2_W-1:0]   prod_mute;
  logic signed [DATA_W-1:0] stage1_q;
  logic [RAMP_W-1:0]        ramp_q;
  logic [DATA_W-1:0]        dout_q;

  always_comb prod_rate = $signed(din) * $signed({1'b0, rate_gain});

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      ramp_q   <= '0;
    end else begin
      stage1_q <= DATA_W'(prod_rate >>> (RATIO_W - 1));
      ramp_q   <= ramp;
    end
  end

  always_comb prod_mute = stage1_q * $signed({1'b0, ramp_q});

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= DATA_W'(prod_mute >>> RAMP_LOG);
  end

  assign dout = dout_q;

  function automatic logic [DATA_W:0] mag(input logic [DATA_W-1:0] v);
    logic signed [DATA_W:0] w;
    w = $signed({v[DATA_W-1], v});
    return (w < 0) ? DATA_W'(0) - w : w;
  endfunction

  p_no_growth_r5: assert property (@(posedge clk) disable iff (rst)
    mag(dout_q) <= mag($past(din, 2)) + 1'b1);
  p_silent_r7: assert property (@(posedge clk) disable iff (rst)
    (ramp == '0) |=> ##1 dout_q == '0);
endmodule

// File: rtl/src_buf_ram.sv
module src_buf_ram #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] port_addr;
  logic [DATA_W-1:0] rdata_q;

  always_comb port_addr = we ? waddr : raddr;

  always_ff @(posedge clk) begin
    if (we) mem[port_addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (!we && re) rdata_q <= mem[port_addr];
  end

  assign rdata = rdata_q;

  p_hold_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    (we || !re) |=> $stable(rdata_q));
endmodule

// File: rtl/src_in_buffer.sv
module src_in_buffer
  import src_buf_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int ADDR_W  = 9,
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_stb,
  input  logic [DATA_W-1:0]  in_left,
  input  logic [DATA_W-1:0]  in_right,
  input  logic [7:0]         ctl_byte,
  input  logic [RATIO_W-1:0] rate_q,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_left,
  output logic [DATA_W-1:0]  rd_right,
  output logic               rd_valid
);
  localparam int CHANNELS = 2;

  logic [ADDR_W-1:0]                 addr_now;
  logic [ADDR_W-1:0]                 addr_s1, addr_s2;
  logic                              vld_s1, vld_s2;
  logic [RATIO_W-1:0]                rate_gain;
  logic [RAMP_W-1:0]                 ramp;
  logic [CHANNELS-1:0][DATA_W-1:0]   chan_in, chan_scaled, chan_rd;
  logic                              rd_valid_q;

  assign chan_in[0] = in_left;
  assign chan_in[1] = in_right;

  src_buf_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .stb(in_stb),
    .delay(ctl_byte[DELAY_W-1:0]), .wr_addr(addr_now)
  );

  src_buf_gain #(.RATIO_W(RATIO_W)) u_gain (
    .clk(clk), .rst(rst), .stb(in_stb), .mute(ctl_byte[7]),
    .ratio(rate_q), .rate_gain(rate_gain), .ramp(ramp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1  <= 1'b0;
      vld_s2  <= 1'b0;
      addr_s1 <= '0;
      addr_s2 <= '0;
    end else begin
      vld_s1  <= in_stb;
      vld_s2  <= vld_s1;
      addr_s1 <= addr_now;
      addr_s2 <= addr_s1;
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    src_buf_scale #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_scale (
      .clk(clk), .rst(rst), .din(chan_in[ch]),
      .rate_gain(rate_gain), .ramp(ramp), .dout(chan_scaled[ch])
    );
    src_buf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst(rst), .we(vld_s2), .waddr(addr_s2),
      .wdata(chan_scaled[ch]), .re(rd_en), .raddr(rd_addr),
      .rdata(chan_rd[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= rd_en && !vld_s2;
  end

  assign rd_left  = chan_rd[0];
  assign rd_right = chan_rd[1];
  assign rd_valid = rd_valid_q;

  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (vld_s2 && rd_en) |=> !rd_valid_q);
  p_read_served_r8: assert property (@(posedge clk) disable iff (rst)
    (!vld_s2 && rd_en) |=> rd_valid_q);
  p_write_lag_r8: assert property (@(posedge clk) disable iff (rst)
    in_stb |=> ##1 vld_s2);
endmodule

// File: tb/test_src_in_buffer.sv
`timescale 1ns/1ps
module test_src_in_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_stb = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [7:0]  ctl_byte = '0;
  logic [15:0] rate_q = 16'h8000;
  logic        rd_en = 1'b0;
  logic [8:0]  rd_addr = '0;
  logic [23:0] rd_left, rd_right;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  int cnt_m = 0;
  int gain_m = 1024;
  logic [23:0] exp_l [512];
  logic [23:0] exp_r [512];
  bit done = 0;

  always #2 clk = ~clk;

  src_in_buffer i_src_in_buffer (
    .clk(clk), .rst(rst), .in_stb(in_stb), .in_left(in_left),
    .in_right(in_right), .ctl_byte(ctl_byte), .rate_q(rate_q),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_left(rd_left),
    .rd_right(rd_right), .rd_valid(rd_valid)
  );

  function automatic logic [23:0] model(input logic [23:0] x,
                                        input logic [15:0] r, input int g);
    longint xs, f, p1, p2;
    xs = longint'($signed(x));
    f  = (r >= 16'h8000) ? 32768 : longint'(r);
    p1 = (xs * f) >>> 15;
    p2 = (p1 * g) >>> 10;
    return p2[23:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drives one strobe; returns the address the model expects
  task automatic push(input logic [23:0] l, input logic [23:0] r,
                      output int addr);
    @(negedge clk);
    in_stb = 1'b1; in_left = l; in_right = r;
    addr = (cnt_m + 16 + int'(ctl_byte[6:0])) % 512;
    exp_l[addr] = model(l, rate_q, gain_m);
    exp_r[addr] = model(r, rate_q, gain_m);
    cnt_m = (cnt_m + 1) % 512;
    if (ctl_byte[7]) begin if (gain_m > 0) gain_m--; end
    else if (gain_m < 1024) gain_m++;
    @(negedge clk);
    in_stb = 1'b0;
  endtask

  task automatic rd(input int addr, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 9'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, {63'd0, rd_valid}, 64'd1);
    check(req, {40'd0, rd_left}, {40'd0, exp_l[addr]});
    check(req, {40'd0, rd_right}, {40'd0, exp_r[addr]});
  endtask

  task automatic push_check(input logic [23:0] l, input logic [23:0] r,
                            input string req);
    int a;
    push(l, r, a);
    @(negedge clk);
    rd(a, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b;
    logic [23:0] hl, hr;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);

    // R1/R2: first pair at offset 16, full gain
    push(24'h123456, 24'h800000, a);
    check("R1 first addr", 64'(a), 64'd16);
    @(negedge clk);
    rd(16, "R1 full gain");

    // R3: largest delay field
    ctl_byte = 8'h7F;
    push(24'h7FFFFF, 24'h000001, a);
    check("R3 max offset", 64'(a), 64'd144);
    @(negedge clk);
    rd(a, "R3 data");
    ctl_byte = 8'h00;

    // R5: ratio above unity clamps, half ratio halves
    rate_q = 16'hFFFF;
    push_check(24'h7FFFFF, 24'h800000, "R5 clamp");
    rate_q = 16'h4000;
    push_check(24'hFFFFFF, 24'h000003, "R5 half");

    // R10: back-to-back strobes
    @(negedge clk);
    in_stb = 1'b1; in_left = 24'h111111; in_right = 24'h222222;
    a = (cnt_m + 16) % 512;
    exp_l[a] = model(24'h111111, rate_q, gain_m);
    exp_r[a] = model(24'h222222, rate_q, gain_m);
    cnt_m++; gain_m = (gain_m < 1024) ? gain_m + 1 : gain_m;
    @(negedge clk);
    in_left = 24'hABCDEF; in_right = 24'h0F0F0F;
    b = (cnt_m + 16) % 512;
    exp_l[b] = model(24'hABCDEF, rate_q, gain_m);
    exp_r[b] = model(24'h0F0F0F, rate_q, gain_m);
    cnt_m++; gain_m = (gain_m < 1024) ? gain_m + 1 : gain_m;
    @(negedge clk);
    in_stb = 1'b0;
    repeat (2) @(negedge clk);
    rd(a, "R10 first");
    rd(b, "R10 second");

    // R9: read colliding with write edge; data must hold
    hl = rd_left; hr = rd_right;
    rate_q = 16'h8000;
    @(negedge clk);
    in_stb = 1'b1; in_left = 24'h000777; in_right = 24'h000888;
    a = (cnt_m + 16) % 512;
    exp_l[a] = model(24'h000777, rate_q, gain_m);
    exp_r[a] = model(24'h000888, rate_q, gain_m);
    cnt_m++;
    @(negedge clk);
    in_stb = 1'b0;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 9'd16;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 dropped", {63'd0, rd_valid}, 64'd0);
    check("R9 hold", {16'd0, rd_left, rd_right}, {16'd0, hl, hr});
    rd(a, "R8 write landed");

    // R2/R4/R5: random traffic, runs counter past 512
    for (int i = 0; i < 700; i++) begin
      ctl_byte = {1'b0, 7'($urandom_range(0, 127))};
      rate_q = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(32768, 65535))
                                           : 16'($urandom);
      push_check(24'($urandom), 24'($urandom), "R2 R4 random");
    end
    check("R4 wrapped", 64'(cnt_m < 512), 64'd1);

    // R6/R7: mute ramp down past zero, then back up
    ctl_byte = 8'h80;
    rate_q = 16'h8000;
    for (int i = 0; i < 1100; i++)
      push_check(24'($urandom), 24'($urandom), "R6 R7 fade out");
    push_check(24'h7FFFFF, 24'h800000, "R7 silent");
    check("R7 zero", {40'd0, rd_left}, 64'd0);
    ctl_byte = 8'h05;
    for (int i = 0; i < 1030; i++)
      push_check(24'($urandom), 24'($urandom), "R6 fade in");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule